// File: doc/BRIEF.md
# Loopback Word-Store Command Slave

This block answers single-word read and write commands from an on-chip bus master. It keeps the written words in an internal array, so a system can run end-to-end transfers before a real storage device is connected. The master puts a command code, an address and write data on the bus and holds them there. The slave shows that it has taken the command with a one-cycle accept strobe. One cycle after that, it returns a one-cycle response.

Writes are non-posted. A write gets a response just as a read does, and the master holds its command until that response arrives. The master then sets the command back to idle. The slave takes no new command until it has issued its response and seen the idle code. The array is indexed by the low address bits, and the upper address bits are ignored.

Top module: `ocp_lbk_slave`

## Requirements
- R1: While reset (synchronous, active low) is asserted, and afterwards while the command is idle (3'b000), `s_cmd_accept` is 0, `s_resp` is NULL (2'b00) and `s_data` is 0.
- R2: `s_cmd_accept` rises in the same cycle that a non-zero command appears while the slave is idle. It stays high for that single cycle only.
- R3: `s_resp` is non-NULL in exactly the cycle after the accept and returns to NULL in the next cycle.
- R4: A write (3'b001) stores `m_data` at array index `m_addr[7:0]` and is answered with DVA (2'b01). `s_data` is 0 in that response cycle.
- R5: A read (3'b010) is answered with DVA, and `s_data` carries the word last written at index `m_addr[7:0]` in that response cycle.
- R6: Any other non-zero command (3'b011 to 3'b111) is answered with ERR (2'b11) and `s_data` 0. The array is left unchanged.
- R7: After a response, no new command is accepted until the master has presented the idle code for at least one cycle. A command still or again present in the response cycle does not get an accept.
- R8: Address bits above bit 7 do not select storage. Two addresses that share bits 7:0 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_cmd | input | 3 | Master command: 000 idle, 001 write, 010 read |
| m_addr | input | 32 | Master word address |
| m_data | input | 32 | Master write data |
| s_cmd_accept | output | 1 | Slave has taken the current command |
| s_resp | output | 2 | Response: 00 none, 01 DVA, 11 ERR |
| s_data | output | 32 | Read data, valid with a DVA read response |

## Verification
The response cycle of one command can coincide with the master already presenting its next command, as a master would if it skipped the idle turn-around. The bench provokes this in a directed case. It replaces the held write with a read in the very cycle the write's response appears and keeps that read up for two more cycles. The bench judges the case by requiring `s_cmd_accept` to stay low and `s_resp` to stay NULL until one idle cycle has passed. The same read is then accepted at once and returns the word just written. Randomly generated commands, with random addresses and occasional illegal codes, are then compared against a bench-side model of the array.

// File: rtl/lbk_pkg.sv
// Package: shared encodings for the loopback word-store slave.
// Assumes a 3-bit command field and a 2-bit response field.
package lbk_pkg;
    localparam int CMD_W  = 3;
    localparam int RESP_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE = 3'b000,
        CMD_WR   = 3'b001,
        CMD_RD   = 3'b010
    } cmd_e;

    typedef enum logic [RESP_W-1:0] {
        RSP_NULL = 2'b00,
        RSP_DVA  = 2'b01,
        RSP_ERR  = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RESP = 2'b01,
        ST_HOLD = 2'b10
    } hs_state_e;
endpackage

// File: rtl/lbk_handshake.sv
// Module: lbk_handshake
// Command/response sequencer. It accepts one command while idle and gives a
// one-cycle response in the next cycle. It then waits for the idle command
// code before it can accept again.
// Assumes the master holds a command until it sees the response.
module lbk_handshake
    import lbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  m_cmd,
    output logic              accept,
    output logic              wr_en,
    output logic              rd_en,
    output logic [RESP_W-1:0] resp,
    output logic              rd_phase
);
    hs_state_e state_q, state_d;
    resp_e     code_q;
    logic      rd_q;
    logic      cmd_seen;
    logic      is_wr, is_rd;

    // Decode the incoming command code.
    always_comb begin
        cmd_seen = (m_cmd != CMD_IDLE);
        is_wr    = (m_cmd == CMD_WR);
        is_rd    = (m_cmd == CMD_RD);
    end

    // Accept and the array strobes, valid only while idle and out of reset.
    always_comb begin
        accept = rst_n && (state_q == ST_IDLE) && cmd_seen;
        wr_en  = accept && is_wr;
        rd_en  = accept && is_rd;
    end

    // Next-state logic of the handshake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = cmd_seen ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!cmd_seen) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and response-code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= RSP_NULL;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                code_q <= (is_wr || is_rd) ? RSP_DVA : RSP_ERR;
                rd_q   <= is_rd;
            end
        end
    end

    // Response outputs, driven only in the response state.
    always_comb begin
        resp     = (state_q == ST_RESP) ? code_q : RSP_NULL;
        rd_phase = (state_q == ST_RESP) && rd_q;
    end

    // R3: a response follows every accept by exactly one cycle
    p_resp_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (resp != RSP_NULL));
    // R3: a response lasts one cycle
    p_resp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp != RSP_NULL) |=> (resp == RSP_NULL));
    // R2: accept is a single-cycle strobe
    p_accept_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    // R7: a command held through the response cycle gets no accept
    p_no_reaccept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((resp != RSP_NULL) && cmd_seen) |=> !accept);
    // R6: an unknown non-zero code is answered with ERR
    p_err_unknown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_wr && !is_rd) |=> (resp == RSP_ERR));
    // R4: a write is answered with DVA
    p_write_dva_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (resp == RSP_DVA));
endmodule

// File: rtl/lbk_store.sv
// Module: lbk_store
// Word array with one registered read port and one write port.
// Assumes the read and write strobes are never high together.
// Contents are not reset.
module lbk_store #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Capture the addressed word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[idx];
    end

    // R7: only one command is ever in flight
    p_single_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/ocp_lbk_slave.sv
// Module: ocp_lbk_slave
// Loopback word-store slave. It answers single-word reads and writes, with a
// response for writes as well as for reads. Storage is indexed by the low
// IDX_W address bits.
// Assumes the master holds its command, address and data until the response.
module ocp_lbk_slave
    import lbk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_data,
    output logic              s_cmd_accept,
    output logic [1:0]        s_resp,
    output logic [DATA_W-1:0] s_data
);
    logic              wr_en, rd_en, rd_phase;
    logic [DATA_W-1:0] rdata;
    logic [IDX_W-1:0]  idx;

    // Word index from the low address bits.
    always_comb idx = m_addr[IDX_W-1:0];

    lbk_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_cmd    (m_cmd),
        .accept   (s_cmd_accept),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .resp     (s_resp),
        .rd_phase (rd_phase)
    );

    lbk_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .re    (rd_en),
        .idx   (idx),
        .wdata (m_data),
        .rdata (rdata)
    );

    // Read data only with a read response, zero otherwise.
    always_comb s_data = rd_phase ? rdata : '0;

    // R4 R6: s_data stays zero unless the response is DVA
    p_data_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != RSP_DVA) |-> (s_data == '0));
    // R8: the full address is defined whenever a command is taken
    p_addr_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_cmd_accept |-> !$isunknown(m_addr));
endmodule

// File: tb/ocp_lbk_slave_bench.sv
`timescale 1ns/1ps
module ocp_lbk_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  m_cmd = 3'b000;
    logic [31:0] m_addr = '0;
    logic [31:0] m_data = '0;
    logic        s_cmd_accept;
    logic [1:0]  s_resp;
    logic [31:0] s_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] model [256];
    bit          valid [256];

    always #2.5 clk = ~clk;

    ocp_lbk_slave u_ocp_lbk_slave (
        .clk(clk), .rst_n(rst_n), .m_cmd(m_cmd), .m_addr(m_addr),
        .m_data(m_data), .s_cmd_accept(s_cmd_accept), .s_resp(s_resp),
        .s_data(s_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_resp(input logic [2:0] c);
        if (c == 3'b001 || c == 3'b010) return 2'b01;
        return 2'b11;
    endfunction

    // One full transfer: present, check accept, check response, go idle.
    task automatic xfer(input logic [2:0] c, input logic [31:0] a, input logic [31:0] d,
                        input bit chk_data, input logic [31:0] exp_q);
        @(negedge clk);
        m_cmd = c; m_addr = a; m_data = d;
        #1;
        check("R2 accept", {31'd0, s_cmd_accept}, 32'd1);
        check("R3 no early resp", {30'd0, s_resp}, 32'd0);
        @(negedge clk);
        check("R3 resp code", {30'd0, s_resp}, {30'd0, exp_resp(c)});
        check("R2 accept single", {31'd0, s_cmd_accept}, 32'd0);
        if (c != 3'b010) check("R6 R4 data quiet", s_data, 32'd0);
        else if (chk_data) check("R5 read data", s_data, exp_q);
        m_cmd = 3'b000;
        @(negedge clk);
        check("R3 resp one cycle", {30'd0, s_resp}, 32'd0);
        if (c == 3'b001) begin
            model[a[7:0]] = d;
            valid[a[7:0]] = 1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 accept in reset", {31'd0, s_cmd_accept}, 32'd0);
        check("R1 resp in reset", {30'd0, s_resp}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resp after reset", {30'd0, s_resp}, 32'd0);
        check("R1 data after reset", s_data, 32'd0);
        check("R1 accept idle", {31'd0, s_cmd_accept}, 32'd0);

        xfer(3'b001, 32'h0000_0010, 32'hA5A5_0001, 0, 0);       // R4
        xfer(3'b010, 32'h0000_0010, 0, 1, 32'hA5A5_0001);       // R5
        xfer(3'b001, 32'hABCD_0122, 32'h1234_5678, 0, 0);       // R8
        xfer(3'b010, 32'h0000_0022, 0, 1, 32'h1234_5678);       // R8 alias
        xfer(3'b101, 32'h0000_0010, 32'hDEAD_BEEF, 0, 0);       // R6
        xfer(3'b111, 32'h0000_0010, 32'hDEAD_BEEF, 0, 0);       // R6
        xfer(3'b010, 32'h0000_0010, 0, 1, 32'hA5A5_0001);       // R6 array intact
        xfer(3'b001, 32'h0000_0000, 32'h0000_00F0, 0, 0);
        xfer(3'b001, 32'h0000_00FF, 32'hFFFF_000F, 0, 0);
        xfer(3'b010, 32'h0000_0000, 0, 1, 32'h0000_00F0);       // R5 low end
        xfer(3'b010, 32'hFFFF_FFFF, 0, 1, 32'hFFFF_000F);       // R8 high end

        // R7: next command presented in the response cycle
        @(negedge clk);
        m_cmd = 3'b001; m_addr = 32'h30; m_data = 32'hC0FF_EE00;
        #1 check("R2 accept collide", {31'd0, s_cmd_accept}, 32'd1);
        @(negedge clk);
        check("R4 resp collide", {30'd0, s_resp}, 32'd1);
        m_cmd = 3'b010;
        #1 check("R7 no accept in resp cycle", {31'd0, s_cmd_accept}, 32'd0);
        @(negedge clk);
        check("R7 no accept held 1", {31'd0, s_cmd_accept}, 32'd0);
        check("R7 no resp held 1", {30'd0, s_resp}, 32'd0);
        @(negedge clk);
        check("R7 no accept held 2", {31'd0, s_cmd_accept}, 32'd0);
        m_cmd = 3'b000;
        model[8'h30] = 32'hC0FF_EE00; valid[8'h30] = 1;
        xfer(3'b010, 32'h30, 0, 1, 32'hC0FF_EE00);              // R7 then R5

        for (int i = 0; i < 400; i++) begin
            logic [2:0]  c;
            logic [31:0] a;
            int          pick;
            pick = $urandom_range(0, 19);
            a = $urandom();
            if (pick < 9) c = 3'b001;
            else if (pick < 18) c = 3'b010;
            else c = 3'($urandom_range(3, 7));
            if ($urandom_range(0, 1) == 1) a[7:0] = a[7:0] & 8'h0F;
            xfer(c, a, $urandom(), valid[a[7:0]], model[a[7:0]]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule